// File: doc/BRIEF.md
# Cache Control Register Bank

This block is the system-control register bank that sits beside a processor's cache. Software reaches it through coprocessor register transfers: a move-to writes one of sixteen register numbers and a move-from reads one back in the same cycle. The bank holds a fixed identification word and a flush trigger. It also holds a control word that switches the cache on, selects a shared user/privileged address mapping and selects monitor mode. Three 32-bit masks give each 2 MB chunk of a 64 MB (26-bit) virtual space its cacheable, updateable and disruptive attribute.

On the access side, the block looks up the chunk of every processor access combinationally. It reports whether the cache may serve the access and whether a write may update the cache. It also reports whether the chunk is disruptive. A write into a disruptive chunk raises a one-cycle flush. A register transfer attempted from user mode raises a trap, has no effect, and reads as zero.

Top module: `cc_regbank`

## Requirements
- R1: Register 0 reads the identification word: designer code in bits 31..24, maker code in 23..16, part code in 15..8, revision in 7..0. A write to register 0 leaves the read value unchanged.
- R2: A privileged write to register 1 raises `flush` for exactly one cycle, in the cycle after the write, whatever the data. Reads of register 1 and of registers 6 to 15 return zero.
- R3: Register 2 bit 0 drives `cache_en`, bit 1 drives `shared_map` and bit 2 drives `monitor`. All three are 0 after reset. Bits 31..3 read as zero whatever was written.
- R4: Registers 3, 4 and 5 hold the cacheable, updateable and disruptive masks. Each reads back exactly the 32-bit value last written.
- R5: Address bits 25..21 give the chunk number n. In the same cycle, `acc_cacheable` equals `cache_en` AND bit n of the cacheable mask. `acc_disruptive` equals bit n of the disruptive mask.
- R6: `acc_cache_wr` is 1 only for a write access whose chunk is cacheable (as in R5) and updateable. A write to a non-updateable chunk leaves the cache unchanged.
- R7: A write access to a disruptive chunk raises `flush` in the next cycle. A read access to that chunk, or a write access to a non-disruptive chunk, does not.
- R8: A register transfer with `cp_user` high raises `cp_trap` in the same cycle and returns zero read data. If the transfer is a write, it changes no register.
- R9: When a register-1 write and a disruptive write occur in the same cycle, `flush` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cp_valid | input | 1 | Register transfer request |
| cp_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| cp_user | input | 1 | Requester is in user mode |
| cp_regsel | input | 4 | Register number |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data, same cycle |
| cp_trap | output | 1 | Invalid-operation trap |
| acc_valid | input | 1 | Processor access present |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 26 | Virtual address of the access |
| acc_cacheable | output | 1 | Cache may serve this access |
| acc_cache_wr | output | 1 | Write may update the cache |
| acc_disruptive | output | 1 | Chunk is marked disruptive |
| flush | output | 1 | One-cycle cache flush |
| cache_en | output | 1 | Cache enabled |
| shared_map | output | 1 | User and privileged modes share one mapping |
| monitor | output | 1 | Monitor mode: run at memory speed, show every access externally |

## Verification
On every cycle, the assertions check the following. The control outputs start at zero after reset. They change only after a privileged register-2 write. A user-mode write leaves them alone. A register-1 write or a disruptive write is always followed by `flush`. Register 0 always reads the identification word. The bench scenarios cover what no local property sees: the lookup of all 32 chunks against several mask patterns, and mask and reserved-bit readback. They also cover the zero reads of unused registers, the one-cycle length of a flush when both causes coincide, and the absence of flush on reads and on writes to non-disruptive chunks.

// File: rtl/cc_regbank.sv
module cc_regbank #(
  parameter logic [7:0] DESIGNER = 8'h5A,
  parameter logic [7:0] MAKER    = 8'h3C,
  parameter logic [7:0] PART     = 8'h07,
  parameter logic [7:0] REV      = 8'h01,
  parameter int         AW       = 26,
  parameter int         CHUNK_W  = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cp_valid,
  input  logic          cp_write,
  input  logic          cp_user,
  input  logic [3:0]    cp_regsel,
  input  logic [31:0]   cp_wdata,
  output logic [31:0]   cp_rdata,
  output logic          cp_trap,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output logic          acc_cacheable,
  output logic          acc_cache_wr,
  output logic          acc_disruptive,
  output logic          flush,
  output logic          cache_en,
  output logic          shared_map,
  output logic          monitor
);
  localparam logic [31:0] ID_WORD = {DESIGNER, MAKER, PART, REV};
  localparam int IDX_W = AW - CHUNK_W;

  logic [2:0]  ctrl_q;
  logic [31:0] cmask_q, umask_q, dmask_q;
  logic        flush_q;
  logic        priv_wr, wr_flush, dis_wr;
  logic [IDX_W-1:0] idx;

  assign priv_wr  = cp_valid && cp_write && !cp_user;
  assign wr_flush = priv_wr && (cp_regsel == 4'd1);
  assign idx      = acc_addr[AW-1:CHUNK_W];
  assign dis_wr   = acc_valid && acc_write && dmask_q[idx];
  assign cp_trap  = cp_valid && cp_user;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= 3'b000;
    else if (priv_wr && cp_regsel == 4'd2) ctrl_q <= cp_wdata[2:0];

  always_ff @(posedge clk) begin
    if (priv_wr && cp_regsel == 4'd3) cmask_q <= cp_wdata;
    if (priv_wr && cp_regsel == 4'd4) umask_q <= cp_wdata;
    if (priv_wr && cp_regsel == 4'd5) dmask_q <= cp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= wr_flush || dis_wr;

  always_comb begin
    cp_rdata = 32'h0;
    if (cp_valid && !cp_write && !cp_user)
      case (cp_regsel)
        4'd0:    cp_rdata = ID_WORD;
        4'd2:    cp_rdata = {29'h0, ctrl_q};
        4'd3:    cp_rdata = cmask_q;
        4'd4:    cp_rdata = umask_q;
        4'd5:    cp_rdata = dmask_q;
        default: cp_rdata = 32'h0;
      endcase
  end

  assign cache_en       = ctrl_q[0];
  assign shared_map     = ctrl_q[1];
  assign monitor        = ctrl_q[2];
  assign acc_cacheable  = cache_en && cmask_q[idx];
  assign acc_cache_wr   = acc_valid && acc_write && acc_cacheable && umask_q[idx];
  assign acc_disruptive = dmask_q[idx];
  assign flush          = flush_q;

  p_ctrl_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cache_en && !shared_map && !monitor));
  p_ctrl_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({cache_en, shared_map, monitor}) |->
      $past(cp_valid && cp_write && !cp_user && cp_regsel == 4'd2));
  p_user_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_user && cp_write) |=> $stable({cache_en, shared_map, monitor}));
  p_reg1_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_write && !cp_user && cp_regsel == 4'd1) |=> flush);
  p_dis_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_disruptive) |=> flush);
  p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_write && !cp_user && cp_regsel == 4'd0) |-> cp_rdata == ID_WORD);
endmodule

// File: tb/sim_cc_regbank.sv
module sim_cc_regbank;
  logic clk = 0, rst_n = 0;
  logic cp_valid = 0, cp_write = 0, cp_user = 0;
  logic [3:0] cp_regsel = 0;
  logic [31:0] cp_wdata = 0, cp_rdata;
  logic cp_trap;
  logic acc_valid = 0, acc_write = 0;
  logic [25:0] acc_addr = 0;
  logic acc_cacheable, acc_cache_wr, acc_disruptive, flush, cache_en, shared_map, monitor;
  int checks = 0, fails = 0;
  bit done = 0;
  localparam logic [31:0] ID = 32'h5A3C0701;

  always #2 clk = ~clk;

  cc_regbank u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpw(input logic [3:0] r, input logic [31:0] d, input logic usr, output logic fl);
    @(negedge clk);
    cp_valid = 1; cp_write = 1; cp_regsel = r; cp_wdata = d; cp_user = usr;
    @(negedge clk);
    fl = flush;
    cp_valid = 0; cp_write = 0; cp_user = 0;
  endtask

  task automatic cpr(input logic [3:0] r, input logic usr, output logic [31:0] d, output logic tr);
    @(negedge clk);
    cp_valid = 1; cp_write = 0; cp_regsel = r; cp_user = usr;
    #1; d = cp_rdata; tr = cp_trap;
    @(negedge clk);
    cp_valid = 0; cp_user = 0;
  endtask

  task automatic sweep(input logic [31:0] c, input logic [31:0] u, input logic [31:0] dm, input logic en);
    logic fl; logic [31:0] rd; logic tr;
    cpw(4'd3, c, 0, fl); cpw(4'd4, u, 0, fl); cpw(4'd5, dm, 0, fl);
    cpw(4'd2, {31'h0, en}, 0, fl);
    cpr(4'd3, 0, rd, tr); chk("R4 cmask", rd, c);
    cpr(4'd4, 0, rd, tr); chk("R4 umask", rd, u);
    cpr(4'd5, 0, rd, tr); chk("R4 dmask", rd, dm);
    for (int n = 0; n < 32; n++)
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        acc_valid = 1; acc_write = w[0];
        acc_addr = {n[4:0], 21'(n * 40503 + w * 777)};
        #1;
        chk("R5 cacheable", {31'h0, acc_cacheable}, {31'h0, en & c[n]});
        chk("R5 disruptive", {31'h0, acc_disruptive}, {31'h0, dm[n]});
        chk("R6 cache_wr", {31'h0, acc_cache_wr}, {31'h0, en & c[n] & u[n] & w[0]});
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        chk("R7 flush", {31'h0, flush}, {31'h0, w[0] & dm[n]});
      end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic fl; logic [31:0] rd; logic tr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R3 reset ctrl", {29'h0, monitor, shared_map, cache_en}, 32'h0);
    chk("R2 reset flush", {31'h0, flush}, 32'h0);
    cpr(4'd0, 0, rd, tr); chk("R1 id", rd, ID);
    cpw(4'd0, 32'hDEADBEEF, 0, fl);
    cpr(4'd0, 0, rd, tr); chk("R1 id after write", rd, ID);
    cpw(4'd1, 32'h0, 0, fl); chk("R2 flush pulse", {31'h0, fl}, 32'h1);
    #1; @(negedge clk); chk("R2 flush one cycle", {31'h0, flush}, 32'h0);
    cpw(4'd1, 32'h12345678, 0, fl); chk("R2 flush any data", {31'h0, fl}, 32'h1);
    cpr(4'd1, 0, rd, tr); chk("R2 reg1 reads 0", rd, 32'h0);
    for (int r = 6; r < 16; r++) begin
      cpr(r[3:0], 0, rd, tr); chk("R2 unused reads 0", rd, 32'h0);
    end
    cpw(4'd2, 32'hFFFFFFFF, 0, fl);
    cpr(4'd2, 0, rd, tr); chk("R3 reserved zero", rd, 32'h7);
    chk("R3 outputs", {29'h0, monitor, shared_map, cache_en}, 32'h7);
    cpw(4'd2, 32'h5, 0, fl);
    chk("R3 bit map", {29'h0, monitor, shared_map, cache_en}, 32'h5);
    cpw(4'd2, 32'h0, 1, fl);
    chk("R8 user write ignored", {29'h0, monitor, shared_map, cache_en}, 32'h5);
    cpw(4'd1, 32'h0, 1, fl); chk("R8 user flush ignored", {31'h0, fl}, 32'h0);
    cpr(4'd0, 1, rd, tr);
    chk("R8 trap", {31'h0, tr}, 32'h1);
    chk("R8 user read zero", rd, 32'h0);
    cpr(4'd0, 0, rd, tr); chk("R8 no trap privileged", {31'h0, tr}, 32'h0);
    sweep(32'hF0F0A5C3, 32'h33CC55AA, 32'h80010240, 1'b1);
    sweep(32'h0F0F5A3C, 32'hFFFF0000, 32'h7FFE0001, 1'b1);
    sweep(32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0);
    cpw(4'd5, 32'h00000004, 0, fl);
    cpw(4'd3, 32'hFFFFFFFF, 1, fl);
    cpr(4'd3, 0, rd, tr); chk("R8 user mask write ignored", rd, 32'hFFFFFFFF);
    @(negedge clk);
    cp_valid = 1; cp_write = 1; cp_regsel = 4'd1; cp_user = 0;
    acc_valid = 1; acc_write = 1; acc_addr = {5'd2, 21'h1234};
    @(negedge clk);
    cp_valid = 0; cp_write = 0; acc_valid = 0; acc_write = 0;
    chk("R9 combined flush", {31'h0, flush}, 32'h1);
    @(negedge clk);
    chk("R9 single cycle", {31'h0, flush}, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule